// File: doc/BRIEF.md
# Correlated Double Sampling Readout Sequencer

This block runs the digital timing for one correlated double sampling readout. A frame start pulse begins a fixed sequence of five phases: a pixel reset strobe, an integration window, a baseline sample strobe, a signal sample strobe and a single ADC conversion start. After the conversion start, the converter returns two words: the held baseline first and the held signal second. The block outputs the signal minus the baseline. Reset charge noise and slow offsets are common to both samples, so they cancel in this difference.

The reset width, integration length and guard length are counted in clock cycles. The block latches them when it accepts a frame start. Once accepted, every frame with the same settings places its sample strobes on the same cycles relative to the frame start pulse. A quiet flag covers the end of integration, both sample cycles and a hold-off before conversion. A cooler drive can use this flag to keep its switching edges away from the sampling instants. A frame start that arrives while a readout is still in progress is dropped, and a sticky flag records it.

Top module: `cds_sequencer`

## Requirements
- R1: After reset, every phase strobe, `conv_start`, `quiet`, `cds_valid` and `overrun` are low, and `cds_out` is zero.
- R2: A frame start sampled while the block is idle starts the reset phase on the next cycle. The phases then follow in this order:
  - `ph_reset` is high for R cycles.
  - `ph_integ` is high for T cycles.
  - `ph_samp1` is high for one cycle.
  - `ph_samp2` is high on the cycle after that.
  - G hold cycles follow.
  - `conv_start` is then high for one cycle.
  
  R, T and G are the latched reset, integration and guard lengths. A reset or integration length of zero acts as one.
- R3: For the same settings, each sample strobe falls on the same cycle offset from the frame start pulse in every frame.
- R4: The three lengths are captured only on the cycle in which a frame start is accepted. Changing them later has no effect on the running frame.
- R5: `quiet` is high during four stretches and low at all other times:
  - the last min(G,T) integration cycles;
  - the `ph_samp1` cycle;
  - the `ph_samp2` cycle;
  - the G hold cycles.
- R6: After `conv_start`, the first word with `adc_valid` high is taken as the baseline and the second as the signal. `adc_valid` at any other time is ignored.
- R7: `cds_out` equals the signal minus the baseline, computed signed and one bit wider than the ADC word. A negative result is output as zero.
- R8: `cds_valid` is high for exactly one cycle, the cycle after the signal word is taken, and `cds_out` holds the result in that cycle.
- R9: A frame start that arrives from the first reset cycle until the signal word is taken is ignored, and the phase timing is unchanged. It sets `overrun`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle request to begin a readout |
| reset_len | input | CNT_W | Reset phase width in cycles |
| integ_len | input | CNT_W | Integration window length in cycles |
| guard_len | input | CNT_W | Quiet guard length in cycles |
| adc_data | input | ADC_W | Converter output word |
| adc_valid | input | 1 | Converter word valid |
| ph_reset | output | 1 | Pixel reset strobe |
| ph_integ | output | 1 | Integration window |
| ph_samp1 | output | 1 | Baseline sample strobe |
| ph_samp2 | output | 1 | Signal sample strobe |
| conv_start | output | 1 | Conversion start pulse |
| quiet | output | 1 | Switching hold-off window |
| cds_out | output | ADC_W | Clamped difference result |
| cds_valid | output | 1 | Result valid pulse |
| overrun | output | 1 | Sticky flag for a dropped frame start |

## Verification
The hardest situations to reach are a frame start during a busy readout and a length change partway through a frame. Either one could disturb the sampling timing without any visible error.

The stimulus handles both inside the frame itself. Right after each accepted start, it writes fresh random lengths. In selected frames, it also fires a second frame start partway through integration and a stray converter word during reset. Every cycle of the frame is still compared with the timing computed from the original lengths. Directed frames add three cases: zero lengths, a guard longer than the integration window, and a signal below the baseline.

// File: rtl/cds_sequencer.sv
module cds_sequencer #(
  parameter int ADC_W = 12,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic [CNT_W-1:0] reset_len,
  input  logic [CNT_W-1:0] integ_len,
  input  logic [CNT_W-1:0] guard_len,
  input  logic [ADC_W-1:0] adc_data,
  input  logic             adc_valid,
  output logic             ph_reset,
  output logic             ph_integ,
  output logic             ph_samp1,
  output logic             ph_samp2,
  output logic             conv_start,
  output logic             quiet,
  output logic [ADC_W-1:0] cds_out,
  output logic             cds_valid,
  output logic             overrun
);

  typedef enum logic [3:0] {
    IDLE, RST, INTG, SMP1, SMP2, HOLD, CONV, WBASE, WSIG
  } state_t;

  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  state_t           st;
  logic [CNT_W-1:0] cnt, lat_tint, lat_guard;
  logic [ADC_W-1:0] base;
  logic signed [ADC_W:0] diff;

  assign diff = $signed({1'b0, adc_data}) - $signed({1'b0, base});

  assign ph_reset   = (st == RST);
  assign ph_integ   = (st == INTG);
  assign ph_samp1   = (st == SMP1);
  assign ph_samp2   = (st == SMP2);
  assign conv_start = (st == CONV);
  assign quiet      = ((st == INTG) && (cnt < lat_guard)) || (st == SMP1) ||
                      (st == SMP2) || (st == HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IDLE;
      cnt       <= ZERO;
      lat_tint  <= ZERO;
      lat_guard <= ZERO;
      base      <= '0;
      cds_out   <= '0;
      cds_valid <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      cds_valid <= 1'b0;
      if (frame_start && st != IDLE) overrun <= 1'b1;
      case (st)
        IDLE: if (frame_start) begin
          lat_tint  <= integ_len;
          lat_guard <= guard_len;
          cnt       <= (reset_len == ZERO) ? ZERO : reset_len - ONE;
          st        <= RST;
        end
        RST: if (cnt == ZERO) begin
          cnt <= (lat_tint == ZERO) ? ZERO : lat_tint - ONE;
          st  <= INTG;
        end else cnt <= cnt - ONE;
        INTG: if (cnt == ZERO) st <= SMP1; else cnt <= cnt - ONE;
        SMP1: st <= SMP2;
        SMP2: if (lat_guard == ZERO) st <= CONV;
              else begin
                cnt <= lat_guard - ONE;
                st  <= HOLD;
              end
        HOLD: if (cnt == ZERO) st <= CONV; else cnt <= cnt - ONE;
        CONV: st <= WBASE;
        WBASE: if (adc_valid) begin
          base <= adc_data;
          st   <= WSIG;
        end
        WSIG: if (adc_valid) begin
          cds_out   <= diff[ADC_W] ? '0 : diff[ADC_W-1:0];
          cds_valid <= 1'b1;
          st        <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cds_sequencer_chk.sv
module cds_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_start,
  input logic ph_reset,
  input logic ph_integ,
  input logic ph_samp1,
  input logic ph_samp2,
  input logic conv_start,
  input logic quiet,
  input logic cds_valid,
  input logic overrun
);

  // R2
  s2_after_s1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph_samp1 |=> ph_samp2);

  // R2
  single_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ph_reset, ph_integ, ph_samp1, ph_samp2, conv_start}));

  // R5
  quiet_at_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_samp1 || ph_samp2) |-> quiet);

  // R5
  quiet_before_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_start) |-> $past(quiet));

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cds_valid |=> !cds_valid);

  // R9
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  // R9
  busy_start_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && (ph_reset || ph_integ || ph_samp1 || ph_samp2 || conv_start))
    |=> overrun);

endmodule

bind cds_sequencer cds_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
  .ph_reset(ph_reset), .ph_integ(ph_integ), .ph_samp1(ph_samp1),
  .ph_samp2(ph_samp2), .conv_start(conv_start), .quiet(quiet),
  .cds_valid(cds_valid), .overrun(overrun)
);

// File: tb/cds_sequencer_bench.sv
module cds_sequencer_bench;
  localparam int ADC_W = 12;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic [CNT_W-1:0] reset_len = '0, integ_len = '0, guard_len = '0;
  logic [ADC_W-1:0] adc_data = '0;
  logic adc_valid = 1'b0;
  logic ph_reset, ph_integ, ph_samp1, ph_samp2, conv_start, quiet;
  logic [ADC_W-1:0] cds_out;
  logic cds_valid, overrun;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cds_sequencer #(.ADC_W(ADC_W), .CNT_W(CNT_W)) u_cds_sequencer (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_diff(input int a, input int b);
    return (b > a) ? b - a : 0;
  endfunction

  // R2 R3 R4 R5 R6 R7 R8 R9: one frame, each cycle compared with computed timing
  task automatic run_frame(input int r, input int t, input int g, input int busy_at,
                           input bit stray, input int a, input int b,
                           input int d1, input int d2);
    int re = (r == 0) ? 1 : r;
    int te = (t == 0) ? 1 : t;
    int gq = (g < te) ? g : te;
    int last = re + te + 2 + g;
    @(negedge clk);
    reset_len = CNT_W'(r); integ_len = CNT_W'(t); guard_len = CNT_W'(g);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    reset_len = CNT_W'($urandom_range(0, 9));   // R4 changes after acceptance
    integ_len = CNT_W'($urandom_range(0, 30));
    guard_len = CNT_W'($urandom_range(0, 9));
    for (int i = 0; i <= last; i++) begin
      chk("R2 ph_reset", int'(ph_reset), int'(i < re));
      chk("R4 ph_integ", int'(ph_integ), int'(i >= re && i < re + te));
      chk("R3 ph_samp1", int'(ph_samp1), int'(i == re + te));
      chk("R3 ph_samp2", int'(ph_samp2), int'(i == re + te + 1));
      chk("R2 conv_start", int'(conv_start), int'(i == last));
      chk("R5 quiet", int'(quiet), int'(i >= re + te - gq && i <= re + te + 1 + g));
      frame_start = (i == busy_at);
      adc_valid = stray && (i == 1);
      adc_data = ADC_W'($urandom_range(0, 4095));
      @(negedge clk);
    end
    frame_start = 1'b0; adc_valid = 1'b0;
    chk("R5 quiet after conv", int'(quiet), 0);
    repeat (d1) @(negedge clk);
    adc_data = ADC_W'(a); adc_valid = 1'b1;
    @(negedge clk);
    adc_valid = 1'b0;
    repeat (d2) begin
      chk("R8 no early valid", int'(cds_valid), 0);
      @(negedge clk);
    end
    adc_data = ADC_W'(b); adc_valid = 1'b1;
    @(negedge clk);
    adc_valid = 1'b0;
    chk("R8 cds_valid", int'(cds_valid), 1);
    chk("R7 cds_out", int'(cds_out), exp_diff(a, b));
    @(negedge clk);
    chk("R8 single pulse", int'(cds_valid), 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 ph_reset", int'(ph_reset), 0);
    chk("R1 quiet", int'(quiet), 0);
    chk("R1 cds_valid", int'(cds_valid), 0);
    chk("R1 overrun", int'(overrun), 0);
    chk("R1 cds_out", int'(cds_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 conv_start", int'(conv_start), 0);

    run_frame(0, 0, 0, -1, 1'b0, 100, 350, 0, 0);
    run_frame(2, 2, 5, -1, 1'b0, 10, 20, 3, 1);
    run_frame(3, 6, 2, -1, 1'b1, 700, 200, 1, 2);   // R7 negative clamps to zero
    run_frame(1, 4, 1, -1, 1'b0, 4095, 4095, 0, 0);
    run_frame(1, 4, 1, -1, 1'b0, 0, 4095, 2, 0);
    for (int k = 0; k < 30; k++)
      run_frame($urandom_range(0, 4), $urandom_range(0, 20), $urandom_range(0, 5),
                -1, 1'($urandom_range(0, 1)), $urandom_range(0, 4095),
                $urandom_range(0, 4095), $urandom_range(0, 3), $urandom_range(0, 3));
    chk("R9 no false overrun", int'(overrun), 0);
    run_frame(2, 8, 3, 5, 1'b0, 50, 900, 1, 1);
    chk("R9 overrun set", int'(overrun), 1);
    run_frame(2, 8, 3, -1, 1'b0, 900, 50, 0, 0);
    chk("R9 overrun sticky", int'(overrun), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL R2 watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule